// File: doc/BRIEF.md
# DMA Channel Interrupt Register Bank

This block keeps the interrupt state for a single DMA channel. Twelve interrupt sources latch into a status word. A mask word decides which latched sources may drive the channel's interrupt line. Two 8-bit counters record how many source-side and destination-side descriptors have completed since software last looked at them. The engine's data path reports what happens through one-cycle pulses. Software reaches the bank through a simple 32-bit word register port, and the block raises one level-sensitive interrupt output.

Software never writes the mask directly. A write to the unmask register clears the mask bits at the positions where the data holds 1. A write to the mask-set register sets them. Status bits are cleared by writing 1 to them. Each completion counter returns its value on a read and clears in the same access. When a counter wraps, a dedicated status bit records the lost count. An access to an offset the bank does not decode is flagged in its own status bit.

Register offsets, in bytes and word-aligned:

| Offset | Register |
|--------|----------|
| 0x00 | status (write 1 to clear) |
| 0x04 | mask (read-only) |
| 0x08 | unmask strobe |
| 0x0C | mask-set strobe |
| 0x10 | source completion count |
| 0x14 | destination completion count |

Every other offset is unmapped, and so is any address whose two low bits are not zero.

Top module: `dma_irq_regbank`

## Requirements
- R1: The status bits, by position, are: 11 pause, 10 DMA done, 9 write-data bus error, 8 read-data bus error, 7 destination descriptor fetch error, 6 source descriptor fetch error, 5 destination count overflow, 4 source count overflow, 3 byte-count overflow, 2 destination descriptor done, 1 source descriptor done, 0 invalid access. An event pulse sets its bit on the clock edge that samples the pulse.
- R2: Writing status (0x00) clears every bit where the data is 1. Bits where the data is 0 keep their value.
- R3: The mask resets to 0xFFF. A write to 0x04 leaves the mask unchanged and does not flag an invalid access.
- R4: A write to 0x08 clears the mask bits where the data is 1. A write to 0x0C sets the mask bits where the data is 1. Both registers read as 0.
- R5: irq_o is high exactly when some status bit is 1 while its mask bit is 0. It follows the registered state with no added delay.
- R6: Each descriptor-done pulse increments its 8-bit counter. An increment from 255 wraps the counter to 0 and also sets the matching count-overflow status bit (4 for source, 5 for destination).
- R7: A read of a counter (0x10 or 0x14) returns its value and clears it. If a done pulse arrives in the same cycle as that read, the counter becomes 1.
- R8: A read or write to an unmapped or misaligned address sets status bit 0. Such a read returns 0, and such a write changes nothing else.
- R9: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: Data bits 31 to 12 are ignored on writes, and every register reads 0 in those bits.
- R11: rd_data_o shows the addressed register on the cycle after rd_en_i. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| src_dscr_done_i | input | 1 | Source descriptor completed (pulse) |
| dst_dscr_done_i | input | 1 | Destination descriptor completed (pulse) |
| dma_done_i | input | 1 | Transfer finished (pulse) |
| pause_i | input | 1 | Channel paused (pulse) |
| bus_err_i | input | 4 | Bus error pulses: [3] write data, [2] read data, [1] destination descriptor fetch, [0] source descriptor fetch |
| byte_ovf_i | input | 1 | Byte counter overflow (pulse) |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps all 4096 unmask patterns over a fixed set of latched sources. A design that mixed up the strobe polarity, or that folded the mask in the wrong way, would get irq_o wrong on some pattern. The bench drives each counter through 256 completions. A counter that saturates, or that wraps without flagging, would show the wrong count or a missing overflow bit. It also checks a completion that lands on the same cycle as the clearing read, where a design that lets the clear win would lose that count. Finally it drives an event and a clear onto the same status bit, and it makes unmapped and misaligned accesses. In the first case a design with the wrong priority drops the event. In the second, a design with a loose decode would corrupt a real register or miss the invalid-access flag.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned NSRC = 12;

  localparam int unsigned B_INV       = 0;
  localparam int unsigned B_SDONE     = 1;
  localparam int unsigned B_DDONE     = 2;
  localparam int unsigned B_BYTE_OVF  = 3;
  localparam int unsigned B_SACCT_OVF = 4;
  localparam int unsigned B_DACCT_OVF = 5;
  localparam int unsigned B_SFETCH    = 6;
  localparam int unsigned B_DFETCH    = 7;
  localparam int unsigned B_RD_ERR    = 8;
  localparam int unsigned B_WR_ERR    = 9;
  localparam int unsigned B_DONE      = 10;
  localparam int unsigned B_PAUSE     = 11;

  // word indices
  localparam int unsigned W_STAT = 0;
  localparam int unsigned W_MASK = 1;
  localparam int unsigned W_UNM  = 2;
  localparam int unsigned W_MSET = 3;
  localparam int unsigned W_SCNT = 4;
  localparam int unsigned W_DCNT = 5;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_MASK, SEL_UNM, SEL_MSET, SEL_SCNT, SEL_DCNT
  } reg_sel_e;
endpackage

// File: rtl/dma_irq_decode.sv
module dma_irq_decode
  import dma_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr_i[ADDR_W-1:2];

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      case (word)
        WORD_W'(W_STAT): sel_o = SEL_STAT;
        WORD_W'(W_MASK): sel_o = SEL_MASK;
        WORD_W'(W_UNM):  sel_o = SEL_UNM;
        WORD_W'(W_MSET): sel_o = SEL_MSET;
        WORD_W'(W_SCNT): sel_o = SEL_SCNT;
        WORD_W'(W_DCNT): sel_o = SEL_DCNT;
        default:         sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dma_irq_acct.sv
module dma_irq_acct #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  // a clearing read restarts the count; a coincident pulse is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= CNT_W'(inc_i);
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = inc_i && !clr_i && (&cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int unsigned N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] w1c_i,
  input  logic [N-1:0] mask_clr_i,
  input  logic [N-1:0] mask_set_i,
  output logic [N-1:0] stat_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] stat_q, mask_q;

  // set after clear: an event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= (stat_q & ~w1c_i) | set_i;
      mask_q <= (mask_q & ~mask_clr_i) | mask_set_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);
endmodule

// File: rtl/dma_irq_regbank.sv
module dma_irq_regbank
  import dma_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              src_dscr_done_i,
  input  logic              dst_dscr_done_i,
  input  logic              dma_done_i,
  input  logic              pause_i,
  input  logic [3:0]        bus_err_i,
  input  logic              byte_ovf_i,
  output logic              irq_o
);
  localparam int unsigned NACCT = 2;

  reg_sel_e    sel;
  logic [NSRC-1:0] wdat, set_v, w1c_v, mclr_v, mset_v, stat_w, mask_w;
  logic [NACCT-1:0] acct_inc, acct_clr, acct_wrap;
  logic [CNT_W-1:0] acct_cnt [NACCT];
  logic [CNT_W-1:0] src_cnt_w, dst_cnt_w;
  logic             bad_acc;
  logic [DATA_W-1:0] rd_mux, rd_q;

  dma_irq_decode #(.ADDR_W(ADDR_W)) u_dec (.addr_i(addr_i), .sel_o(sel));

  assign wdat    = wr_data_i[NSRC-1:0];
  assign bad_acc = (wr_en_i || rd_en_i) && (sel == SEL_NONE);
  assign w1c_v   = (wr_en_i && sel == SEL_STAT) ? wdat : '0;
  assign mclr_v  = (wr_en_i && sel == SEL_UNM)  ? wdat : '0;
  assign mset_v  = (wr_en_i && sel == SEL_MSET) ? wdat : '0;

  assign acct_inc = {dst_dscr_done_i, src_dscr_done_i};
  assign acct_clr = {rd_en_i && sel == SEL_DCNT, rd_en_i && sel == SEL_SCNT};

  for (genvar g = 0; g < NACCT; g++) begin : g_acct
    dma_irq_acct #(.CNT_W(CNT_W)) u_acct (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (acct_inc[g]),
      .clr_i (acct_clr[g]),
      .cnt_o (acct_cnt[g]),
      .wrap_o(acct_wrap[g])
    );
  end

  assign src_cnt_w = acct_cnt[0];
  assign dst_cnt_w = acct_cnt[1];

  always_comb begin
    set_v              = '0;
    set_v[B_INV]       = bad_acc;
    set_v[B_SDONE]     = src_dscr_done_i;
    set_v[B_DDONE]     = dst_dscr_done_i;
    set_v[B_BYTE_OVF]  = byte_ovf_i;
    set_v[B_SACCT_OVF] = acct_wrap[0];
    set_v[B_DACCT_OVF] = acct_wrap[1];
    set_v[B_SFETCH]    = bus_err_i[0];
    set_v[B_DFETCH]    = bus_err_i[1];
    set_v[B_RD_ERR]    = bus_err_i[2];
    set_v[B_WR_ERR]    = bus_err_i[3];
    set_v[B_DONE]      = dma_done_i;
    set_v[B_PAUSE]     = pause_i;
  end

  dma_irq_status #(.N(NSRC)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_v),
    .w1c_i     (w1c_v),
    .mask_clr_i(mclr_v),
    .mask_set_i(mset_v),
    .stat_o    (stat_w),
    .mask_o    (mask_w),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STAT: rd_mux = DATA_W'(stat_w);
      SEL_MASK: rd_mux = DATA_W'(mask_w);
      SEL_SCNT: rd_mux = DATA_W'(src_cnt_w);
      SEL_DCNT: rd_mux = DATA_W'(dst_cnt_w);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/dma_irq_regbank_chk.sv
module dma_irq_regbank_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned NSRC   = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              src_dscr_done_i,
  input logic              dst_dscr_done_i,
  input logic              dma_done_i,
  input logic              pause_i,
  input logic [3:0]        bus_err_i,
  input logic              byte_ovf_i,
  input logic              irq_o,
  input logic [NSRC-1:0]   stat_i,
  input logic [NSRC-1:0]   mask_i,
  input logic [CNT_W-1:0]  src_cnt_i
);
  logic any_evt;
  assign any_evt = src_dscr_done_i | dst_dscr_done_i | dma_done_i | pause_i |
                   (|bus_err_i) | byte_ovf_i;

  p_evt_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> stat_i[11]);

  p_w1c_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0 && !rd_en_i && !any_evt)
      |=> ((stat_i & $past(wr_data_i[NSRC-1:0])) == '0));

  p_unmask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(8))
      |=> ((mask_i & $past(wr_data_i[NSRC-1:0])) == '0));

  p_irq_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_evt && !wr_en_i && !rd_en_i) |=> $stable(irq_o));

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_dscr_done_i && !(rd_en_i && addr_i == ADDR_W'(16)) && (&src_cnt_i))
      |=> (stat_i[4] && src_cnt_i == '0));

  p_cor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(16))
      |=> (src_cnt_i == CNT_W'($past(src_dscr_done_i))));

  p_bad_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[1:0] != 2'b00) |=> (rd_data_o == '0 && stat_i[0]));

  p_rsvd_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_data_o[DATA_W-1:NSRC] == '0));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind dma_irq_regbank dma_irq_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NSRC(12)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .src_dscr_done_i(src_dscr_done_i), .dst_dscr_done_i(dst_dscr_done_i),
  .dma_done_i(dma_done_i), .pause_i(pause_i), .bus_err_i(bus_err_i),
  .byte_ovf_i(byte_ovf_i), .irq_o(irq_o), .stat_i(stat_w), .mask_i(mask_w),
  .src_cnt_i(src_cnt_w)
);

// File: tb/sim_dma_irq_regbank.sv
`timescale 1ns/1ps
module sim_dma_irq_regbank;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] wr_data_i = '0, rd_data_o;
  logic        src_dscr_done_i = 0, dst_dscr_done_i = 0, dma_done_i = 0;
  logic        pause_i = 0, byte_ovf_i = 0, irq_o;
  logic [3:0]  bus_err_i = '0;

  int n_chk = 0, n_bad = 0;
  logic [11:0] exp_stat = '0, exp_mask = 12'hFFF;
  int cnt_s = 0, cnt_d = 0;
  logic [31:0] rv;

  always #2 clk_i = ~clk_i;

  dma_irq_regbank u0 (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic drive_evt(input logic [11:0] v);
    src_dscr_done_i = v[1]; dst_dscr_done_i = v[2]; byte_ovf_i = v[3];
    bus_err_i = v[9:6]; dma_done_i = v[10]; pause_i = v[11];
  endtask

  task automatic model_evt(input logic [11:0] v);
    if (v[1]) begin
      if (cnt_s == 255) begin cnt_s = 0; exp_stat[4] = 1'b1; end else cnt_s++;
    end
    if (v[2]) begin
      if (cnt_d == 255) begin cnt_d = 0; exp_stat[5] = 1'b1; end else cnt_d++;
    end
    exp_stat = exp_stat | (v & 12'hFCE);
  endtask

  task automatic pulse(input logic [11:0] v);
    @(negedge clk_i); drive_evt(v);
    @(negedge clk_i); drive_evt('0);
    model_evt(v);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i); rd_en_i = 1'b0; d = rd_data_o;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog (all) actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // reset state
    chk("R5 irq after reset", 32'(irq_o), 0);
    rd(8'h00, rv); chk("R1 status after reset", rv, 0);
    rd(8'h04, rv); chk("R3 mask reset", rv, 32'hFFF);
    rd(8'h10, rv); chk("R7 src count reset", rv, 0);

    // mask is read-only and mapped
    wr(8'h04, 32'h0);
    rd(8'h04, rv); chk("R3 mask write ignored", rv, 32'hFFF);
    rd(8'h00, rv); chk("R3 no invalid flag", rv, 0);

    // each event source, one at a time
    for (int i = 1; i < 12; i++) begin
      if (i == 4 || i == 5) continue;
      pulse(12'(1) << i);
      rd(8'h00, rv); chk("R1 event sets bit", rv, 32'(exp_stat));
      chk("R5 masked source quiet", 32'(irq_o), 0);
      wr(8'h08, 32'(1) << i); exp_mask[i] = 1'b0;
      chk("R5 unmasked source raises irq", 32'(irq_o), 1);
      rd(8'h08, rv); chk("R4 unmask reads zero", rv, 0);
      wr(8'h00, 32'(1) << i); exp_stat[i] = 1'b0;
      rd(8'h00, rv); chk("R2 w1c clears bit", rv, 32'(exp_stat));
      chk("R5 irq drops", 32'(irq_o), 0);
      wr(8'h0C, 32'(1) << i); exp_mask[i] = 1'b1;
      rd(8'h0C, rv); chk("R4 mask-set reads zero", rv, 0);
      rd(8'h04, rv); chk("R4 mask-set restores", rv, 32'(exp_mask));
    end

    // writing zeros leaves status
    pulse(12'hFCE);
    wr(8'h00, 32'h0);
    rd(8'h00, rv); chk("R2 zero write keeps bits", rv, 32'(exp_stat));

    // exhaustive unmask sweep against fixed status
    for (int m = 0; m < 4096; m++) begin
      wr(8'h0C, 32'hFFF);
      wr(8'h08, 32'(m)); exp_mask = ~12'(m);
      chk("R5 irq sweep", 32'(irq_o), 32'(|(exp_stat & ~exp_mask)));
      if ((m & 255) == 0) begin
        rd(8'h04, rv); chk("R4 mask sweep", rv, 32'(exp_mask));
      end
    end
    wr(8'h0C, 32'hFFF); exp_mask = 12'hFFF;
    wr(8'h00, 32'hFFF); exp_stat = '0;

    // counters: clear, then 256 completions wrap to zero
    rd(8'h10, rv); cnt_s = 0;
    rd(8'h14, rv); cnt_d = 0;
    for (int k = 0; k < 256; k++) pulse(12'h006);
    rd(8'h10, rv); chk("R6 src wraps to zero", rv, 0); cnt_s = 0;
    rd(8'h14, rv); chk("R6 dst wraps to zero", rv, 0); cnt_d = 0;
    rd(8'h00, rv); chk("R6 overflow bits", rv, 32'(exp_stat));
    chk("R6 both overflow set", rv & 32'h30, 32'h30);
    wr(8'h00, 32'hFFF); exp_stat = '0;
    for (int k = 0; k < 255; k++) pulse(12'h002);
    rd(8'h10, rv); chk("R6 count 255 no wrap", rv, 255); cnt_s = 0;
    rd(8'h00, rv); chk("R6 no overflow at 255", rv & 32'h10, 0);
    for (int k = 0; k < 3; k++) pulse(12'h004);
    rd(8'h14, rv); chk("R7 dst count read", rv, 3); cnt_d = 0;
    rd(8'h14, rv); chk("R7 cleared by read", rv, 0);

    // done pulse coinciding with clearing read
    pulse(12'h002); pulse(12'h002);
    @(negedge clk_i); addr_i = 8'h10; rd_en_i = 1'b1; src_dscr_done_i = 1'b1;
    @(negedge clk_i); rd_en_i = 1'b0; src_dscr_done_i = 1'b0;
    chk("R7 read returns old", rd_data_o, 2);
    chk("R11 read latency one cycle", rd_data_o, 2);
    @(negedge clk_i);
    chk("R11 read data holds", rd_data_o, 2);
    rd(8'h10, rv); chk("R7 coincident pulse kept", rv, 1);
    wr(8'h00, 32'hFFF); exp_stat = '0;

    // unmapped and misaligned accesses
    rd(8'h40, rv); chk("R8 unmapped read zero", rv, 0);
    rd(8'h00, rv); chk("R8 invalid flag on read", rv, 1);
    wr(8'h00, 32'h1);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h04, rv); chk("R8 unmapped write no effect", rv, 32'hFFF);
    rd(8'h00, rv); chk("R8 invalid flag on write", rv, 1);
    wr(8'h00, 32'h1);
    wr(8'h09, 32'hFFF);
    rd(8'h04, rv); chk("R8 misaligned write ignored", rv, 32'hFFF);
    rd(8'h05, rv); chk("R8 misaligned read zero", rv, 0);
    rd(8'h00, rv); chk("R8 misaligned flagged", rv, 1);
    wr(8'h00, 32'h1);

    // event beats clear
    pulse(12'h400);
    @(negedge clk_i); addr_i = 8'h00; wr_data_i = 32'h400; wr_en_i = 1'b1; dma_done_i = 1'b1;
    @(negedge clk_i); wr_en_i = 1'b0; dma_done_i = 1'b0;
    rd(8'h00, rv); chk("R9 event wins over clear", rv, 32'h400);
    wr(8'h00, 32'h400);

    // reserved upper bits
    wr(8'h08, 32'hFFFF_F000);
    rd(8'h04, rv); chk("R10 upper unmask bits ignored", rv, 32'hFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h04, rv); chk("R10 mask upper reads zero", rv, 0);
    pulse(12'hFCE);
    wr(8'h00, 32'hFFFF_F000);
    rd(8'h00, rv); chk("R10 status upper ignored", rv, 32'(exp_stat));
    chk("R5 all unmasked irq", 32'(irq_o), 1);

    summary();
  end
endmodule